// File: doc/BRIEF.md
# Card Supply Converter Controller

This block sequences the on-chip converter that powers the card slot. Software sets or clears an enable bit through a write strobe. The converter starts only when that bit is set and a card is detected. It then goes through a timed ramp into the running state. The controller keeps the converter interlocked with the card-detect line. If the card is pulled out while the converter is ramping or running, the controller shuts it down on its own and clears the enable bit. Software must then write the bit again before the converter can restart.

The block also produces the converter's clock as a one-cycle enable pulse, derived from the system clock by a programmable divider. It latches the card voltage level and the pump/regulator mode when a turn-on starts. It checks power-down requests and refuses any that arrive while the converter is not fully off, raising a sticky error flag when it does.

Top module: `csup_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (off), `enable_o`, `conv_en_o`, `ready_o`, `pd_grant_o` and `pd_err_o` are 0, and the divider code is 1, so `conv_tick_o` is high on every second cycle.
- R2: A cycle with `en_wr_i` high loads `en_wdata_i` into the enable bit, and `enable_o` shows the new value from the next cycle.
- R3: The card-detect input passes through a two-flop synchronizer. While the synchronized value is low, the state stays off (code 0), even when the enable bit is set.
- R4: When the state is off, the enable bit is set and the card is present, the state moves to ramp (code 1). It moves to on (code 2) once RAMP_TICKS divider pulses have been seen in ramp. `ready_o` is high only in state 2.
- R5: Card removal in ramp or on moves the state to shutdown (code 3) and clears the enable bit on the same edge. This clearing takes priority over a write made in that same cycle.
- R6: A cleared enable bit in ramp or on moves the state to shutdown. `conv_en_o` is high only in states 1 and 2.
- R7: Shutdown lasts SHUT_TICKS divider pulses and then returns to off. The card-detect input and the enable bit have no effect on the state during shutdown.
- R8: A power-down request in state 0 gives a one-cycle `pd_grant_o` pulse on the next cycle and clears `pd_err_o`.
- R9: A power-down request in any other state gives no grant and sets `pd_err_o`. The flag stays set until a request is granted.
- R10: With divider code P, `conv_tick_o` is a one-cycle pulse every P+1 cycles. P=0 keeps it high all the time.
- R11: The divider code is taken from `psc_i` only while the state is not on. A change made while the state is on has no effect on the tick period.
- R12: `vsel_o` and `mode_o` capture `vsel_i` and `mode_i` on the off-to-ramp transition and hold those values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| card_pres_i | input | 1 | Card-detect input, asynchronous |
| vsel_i | input | 2 | Requested card voltage level code |
| mode_i | input | 1 | Requested mode: 1 pump, 0 regulator |
| pd_req_i | input | 1 | Power-down request |
| psc_i | input | 4 | Divider code P (divide by P+1) |
| conv_en_o | output | 1 | Converter enable |
| ready_o | output | 1 | Converter fully on |
| state_o | output | 2 | 0 off, 1 ramp, 2 on, 3 shutdown |
| enable_o | output | 1 | Current enable bit |
| vsel_o | output | 2 | Latched voltage level code |
| mode_o | output | 1 | Latched mode |
| conv_tick_o | output | 1 | Converter clock enable pulse |
| pd_grant_o | output | 1 | Power-down accepted |
| pd_err_o | output | 1 | Sticky flag: a power-down request was refused |

## Verification
The bench removes the card during ramp, during on and during shutdown. A design without the interlock would keep driving the converter after removal, or would restart by itself because the enable bit was never cleared. It changes the divider code while the converter is on and checks the tick period. A design that failed to freeze the code would speed up the converter clock under load. It also checks that the shutdown timer stays fixed when the card is reinserted. Power-down requests are issued in both off and on. A wrong design would grant one while the converter runs, or would lose the sticky error flag.

// File: rtl/csup_pkg.sv
package csup_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RAMP = 2'd1,
        ST_ON   = 2'd2,
        ST_SHUT = 2'd3
    } csup_state_e;

endpackage

// File: rtl/csup_sync.sv
module csup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = d_i;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/csup_clkdiv.sv
module csup_clkdiv #(
    parameter int          PW      = 4,
    parameter logic [3:0]  PSC_RST = 4'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic [PW-1:0] psc_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [PW-1:0] psc;
        logic [PW-1:0] cnt;
        logic          tick;
    } div_regs_t;

    div_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!hold_i) r_d.psc = psc_i;
        if (r_q.cnt >= r_q.psc) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt  = r_q.cnt + 1'b1;
            r_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.psc  <= PW'(PSC_RST);
            r_q.cnt  <= '0;
            r_q.tick <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tick_o = r_q.tick;

    AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(r_q.psc)); // R11

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.tick && r_q.psc != '0) |=> !r_q.tick); // R10
endmodule

// File: rtl/csup_fsm.sv
module csup_fsm
    import csup_pkg::*;
#(
    parameter int RAMP_TICKS = 4,
    parameter int SHUT_TICKS = 4,
    parameter int LW         = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr_i,
    input  logic          en_wdata_i,
    input  logic          pres_i,
    input  logic          tick_i,
    input  logic [LW-1:0] lvl_i,
    input  logic          mode_i,
    input  logic          pd_req_i,
    output csup_state_e   state_o,
    output logic          en_o,
    output logic [LW-1:0] lvl_o,
    output logic          mode_o,
    output logic          pd_grant_o,
    output logic          pd_err_o
);
    localparam int TMAX = (RAMP_TICKS > SHUT_TICKS) ? RAMP_TICKS : SHUT_TICKS;
    localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [TW-1:0] RAMP_LAST = TW'(RAMP_TICKS - 1);
    localparam logic [TW-1:0] SHUT_LAST = TW'(SHUT_TICKS - 1);

    typedef struct packed {
        csup_state_e   state;
        logic          en;
        logic [TW-1:0] timer;
        logic [LW-1:0] lvl;
        logic          mode;
        logic          grant;
        logic          err;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.grant = 1'b0;
        if (en_wr_i) r_d.en = en_wdata_i;

        unique case (r_q.state)
            ST_OFF: begin
                if (r_q.en && pres_i) begin
                    r_d.state = ST_RAMP;
                    r_d.timer = '0;
                    r_d.lvl   = lvl_i;
                    r_d.mode  = mode_i;
                end
            end
            ST_RAMP: begin
                if (!pres_i) begin
                    r_d.state = ST_SHUT;
                    r_d.timer = '0;
                    r_d.en    = 1'b0;
                end else if (!r_q.en) begin
                    r_d.state = ST_SHUT;
                    r_d.timer = '0;
                end else if (tick_i) begin
                    if (r_q.timer == RAMP_LAST) begin
                        r_d.state = ST_ON;
                        r_d.timer = '0;
                    end else begin
                        r_d.timer = r_q.timer + 1'b1;
                    end
                end
            end
            ST_ON: begin
                if (!pres_i) begin
                    r_d.state = ST_SHUT;
                    r_d.timer = '0;
                    r_d.en    = 1'b0;
                end else if (!r_q.en) begin
                    r_d.state = ST_SHUT;
                    r_d.timer = '0;
                end
            end
            default: begin
                if (tick_i) begin
                    if (r_q.timer == SHUT_LAST) begin
                        r_d.state = ST_OFF;
                        r_d.timer = '0;
                    end else begin
                        r_d.timer = r_q.timer + 1'b1;
                    end
                end
            end
        endcase

        if (pd_req_i) begin
            if (r_q.state == ST_OFF) begin
                r_d.grant = 1'b1;
                r_d.err   = 1'b0;
            end else begin
                r_d.err   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;
            r_q.en    <= 1'b0;
            r_q.timer <= '0;
            r_q.lvl   <= '0;
            r_q.mode  <= 1'b0;
            r_q.grant <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o    = r_q.state;
    assign en_o       = r_q.en;
    assign lvl_o      = r_q.lvl;
    assign mode_o     = r_q.mode;
    assign pd_grant_o = r_q.grant;
    assign pd_err_o   = r_q.err;

    AST_NO_START_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_OFF && !pres_i) |=> r_q.state == ST_OFF); // R3

    AST_REMOVAL_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_RAMP || r_q.state == ST_ON) && !pres_i)
        |=> (r_q.state == ST_SHUT && !r_q.en)); // R5

    AST_PD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req_i && r_q.state != ST_OFF) |=> (!r_q.grant && r_q.err)); // R9

    AST_SHUT_NO_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SHUT && !tick_i) |=> r_q.state == ST_SHUT); // R7

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_OFF) |=> $stable(r_q.lvl)); // R12
endmodule

// File: rtl/csup_ctrl.sv
module csup_ctrl
    import csup_pkg::*;
#(
    parameter int         PW          = 4,
    parameter logic [3:0] PSC_RST     = 4'd1,
    parameter int         RAMP_TICKS  = 4,
    parameter int         SHUT_TICKS  = 4,
    parameter int         SYNC_STAGES = 2,
    parameter int         LW          = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr_i,
    input  logic          en_wdata_i,
    input  logic          card_pres_i,
    input  logic [LW-1:0] vsel_i,
    input  logic          mode_i,
    input  logic          pd_req_i,
    input  logic [PW-1:0] psc_i,
    output logic          conv_en_o,
    output logic          ready_o,
    output logic [1:0]    state_o,
    output logic          enable_o,
    output logic [LW-1:0] vsel_o,
    output logic          mode_o,
    output logic          conv_tick_o,
    output logic          pd_grant_o,
    output logic          pd_err_o
);
    logic        pres_s;
    logic        tick;
    csup_state_e state;

    csup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (card_pres_i),
        .q_o   (pres_s)
    );

    csup_clkdiv #(.PW(PW), .PSC_RST(PSC_RST)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (state == ST_ON),
        .psc_i  (psc_i),
        .tick_o (tick)
    );

    csup_fsm #(.RAMP_TICKS(RAMP_TICKS), .SHUT_TICKS(SHUT_TICKS), .LW(LW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr_i    (en_wr_i),
        .en_wdata_i (en_wdata_i),
        .pres_i     (pres_s),
        .tick_i     (tick),
        .lvl_i      (vsel_i),
        .mode_i     (mode_i),
        .pd_req_i   (pd_req_i),
        .state_o    (state),
        .en_o       (enable_o),
        .lvl_o      (vsel_o),
        .mode_o     (mode_o),
        .pd_grant_o (pd_grant_o),
        .pd_err_o   (pd_err_o)
    );

    assign state_o     = state;
    assign conv_en_o   = (state == ST_RAMP) || (state == ST_ON);
    assign ready_o     = (state == ST_ON);
    assign conv_tick_o = tick;

    AST_GRANT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req_i && state == ST_OFF) |=> (pd_grant_o && !pd_err_o)); // R8
endmodule

// File: tb/csup_ctrl_test.sv
module csup_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr_i = 1'b0, en_wdata_i = 1'b0, card_pres_i = 1'b0;
    logic [1:0] vsel_i = 2'd0;
    logic       mode_i = 1'b0, pd_req_i = 1'b0;
    logic [3:0] psc_i = 4'd1;
    logic       conv_en_o, ready_o, enable_o, mode_o, conv_tick_o, pd_grant_o, pd_err_o;
    logic [1:0] state_o, vsel_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam int RAMP_T = 4;
    localparam int SHUT_T = 4;

    csup_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .card_pres_i(card_pres_i), .vsel_i(vsel_i), .mode_i(mode_i),
        .pd_req_i(pd_req_i), .psc_i(psc_i), .conv_en_o(conv_en_o),
        .ready_o(ready_o), .state_o(state_o), .enable_o(enable_o),
        .vsel_o(vsel_o), .mode_o(mode_o), .conv_tick_o(conv_tick_o),
        .pd_grant_o(pd_grant_o), .pd_err_o(pd_err_o)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int m_state, m_en, m_timer, m_lvl, m_mode, m_grant, m_err;
    int m_psc, m_cnt, m_tick, m_s0, m_s1;
    int n_state, n_en, n_timer, n_lvl, n_mode, n_grant, n_err;
    int n_psc, n_cnt, n_tick;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_en = 0; m_timer = 0; m_lvl = 0; m_mode = 0;
            m_grant = 0; m_err = 0; m_psc = 1; m_cnt = 0; m_tick = 0;
            m_s0 = 0; m_s1 = 0;
        end else begin
            n_psc = (m_state == 2) ? m_psc : int'(psc_i);
            if (m_cnt >= m_psc) begin n_cnt = 0; n_tick = 1; end
            else begin n_cnt = m_cnt + 1; n_tick = 0; end
            n_state = m_state; n_timer = m_timer; n_lvl = m_lvl; n_mode = m_mode;
            n_en = en_wr_i ? int'(en_wdata_i) : m_en;
            n_grant = 0; n_err = m_err;
            if (m_state == 0) begin
                if (m_en == 1 && m_s1 == 1) begin
                    n_state = 1; n_timer = 0; n_lvl = vsel_i; n_mode = mode_i;
                end
            end else if (m_state == 1 || m_state == 2) begin
                if (m_s1 == 0) begin n_state = 3; n_timer = 0; n_en = 0; end
                else if (m_en == 0) begin n_state = 3; n_timer = 0; end
                else if (m_state == 1 && m_tick == 1) begin
                    if (m_timer == RAMP_T - 1) begin n_state = 2; n_timer = 0; end
                    else n_timer = m_timer + 1;
                end
            end else if (m_tick == 1) begin
                if (m_timer == SHUT_T - 1) begin n_state = 0; n_timer = 0; end
                else n_timer = m_timer + 1;
            end
            if (pd_req_i) begin
                if (m_state == 0) begin n_grant = 1; n_err = 0; end
                else n_err = 1;
            end
            m_s1 = m_s0; m_s0 = card_pres_i;
            m_state = n_state; m_en = n_en; m_timer = n_timer; m_lvl = n_lvl;
            m_mode = n_mode; m_grant = n_grant; m_err = n_err;
            m_psc = n_psc; m_cnt = n_cnt; m_tick = n_tick;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4",  "state",    state_o,     m_state);
            chk("R4",  "ready",    ready_o,     m_state == 2);
            chk("R6",  "conv_en",  conv_en_o,   m_state == 1 || m_state == 2);
            chk("R2",  "enable",   enable_o,    m_en);
            chk("R10", "tick",     conv_tick_o, m_tick);
            chk("R12", "vsel",     vsel_o,      m_lvl);
            chk("R12", "mode",     mode_o,      m_mode);
            chk("R8",  "grant",    pd_grant_o,  m_grant);
            chk("R9",  "err",      pd_err_o,    m_err);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_en(input logic v);
        en_wr_i = 1'b1; en_wdata_i = v;
        @(negedge clk);
        en_wr_i = 1'b0;
    endtask

    task automatic wait_state(input int s, input int maxc, input string tag);
        int n = 0;
        while (int'(state_o) != s && n < maxc) begin @(negedge clk); n++; end
        chk(tag, "state reached", state_o, s);
    endtask

    task automatic count_ticks(input int n, input int exp, input string tag);
        int c = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (conv_tick_o) c++; end
        chk(tag, "tick count", c, exp);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "state", state_o, 0);
        chk("R1", "enable", enable_o, 0);
        chk("R1", "conv_en", conv_en_o, 0);
        chk("R1", "err", pd_err_o, 0);
        count_ticks(6, 3, "R1");

        // R3 interlock: enable set, card absent
        wr_en(1'b1);
        cyc(12);
        chk("R3", "state with card absent", state_o, 0);
        chk("R2", "enable kept", enable_o, 1);

        // R4 turn-on with level capture
        vsel_i = 2'd2; mode_i = 1'b1; card_pres_i = 1'b1;
        wait_state(1, 10, "R4");
        wait_state(2, 40, "R4");
        chk("R4", "ready", ready_o, 1);
        chk("R12", "vsel latched", vsel_o, 2);

        // R12 inputs change while on
        vsel_i = 2'd1; mode_i = 1'b0;
        cyc(4);
        chk("R12", "vsel held", vsel_o, 2);
        chk("R12", "mode held", mode_o, 1);

        // R9 refused power-down
        pd_req_i = 1'b1; @(negedge clk); pd_req_i = 1'b0;
        chk("R9", "err set", pd_err_o, 1);
        chk("R9", "no grant", pd_grant_o, 0);

        // R11 divider code frozen while on
        psc_i = 4'd0;
        cyc(2);
        count_ticks(8, 4, "R11");

        // R6 software turn-off
        wr_en(1'b0);
        wait_state(3, 10, "R6");
        chk("R6", "conv_en in shutdown", conv_en_o, 0);
        wait_state(0, 100, "R7");

        // R10 P=0 constant pulse, then P=3
        cyc(4);
        count_ticks(4, 4, "R10");
        psc_i = 4'd3;
        cyc(3);
        count_ticks(16, 4, "R10");

        // R8 power-down granted in off
        pd_req_i = 1'b1; @(negedge clk); pd_req_i = 1'b0;
        chk("R8", "grant", pd_grant_o, 1);
        chk("R8", "err cleared", pd_err_o, 0);

        // R5 removal while on
        wr_en(1'b1);
        wait_state(2, 200, "R4");
        card_pres_i = 1'b0;
        wait_state(3, 10, "R5");
        chk("R5", "enable cleared", enable_o, 0);
        // R7 reinsertion and write ignored during shutdown
        card_pres_i = 1'b1;
        en_wr_i = 1'b1; en_wdata_i = 1'b1; @(negedge clk); en_wr_i = 1'b0;
        cyc(2);
        chk("R7", "still shutdown", state_o, 3);
        wr_en(1'b0);
        wait_state(0, 100, "R7");
        cyc(10);
        chk("R5", "no restart without rewrite", state_o, 0);

        // R5 removal during ramp, with a write in the same cycle
        wr_en(1'b1);
        wait_state(1, 10, "R4");
        card_pres_i = 1'b0;
        cyc(2);
        en_wr_i = 1'b1; en_wdata_i = 1'b1; @(negedge clk); en_wr_i = 1'b0;
        wait_state(3, 10, "R5");
        chk("R5", "enable cleared in ramp", enable_o, 0);
        wait_state(0, 100, "R7");
        cyc(4);
        finish_run();
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule